// File: doc/BRIEF.md
# Dual-Slope Buffered PWM Timer

This block is a 16-bit up/down timer that produces symmetric, frequency-correct pulse-width modulation on two compare channels, A and B. The counter climbs from zero to a ceiling value and then descends back to zero, one step per prescaler tick. Each channel compares the count against its own threshold and drives an output pin from the result. Because every period has equal rising and falling slopes, the pulses stay centred on the period.

Software writes the two thresholds and a dedicated ceiling value through a narrow write port. These writes land in shadow buffers. The live values take them only at the bottom of the count, so a new duty or frequency never splits a period. A select input makes channel A's threshold act as the ceiling. This allows the frequency to change safely at run time. In that arrangement channel A stops producing PWM and can instead emit a 50% square wave that flips once per period.

Top module: `dual_slope_pwm`

## Requirements
- R1: Reset clears the count, every shadow and live register, the toggle state and both pins to 0, and the prescaler to stopped.
- R2: Prescaler select codes 1, 2, 3, 4 and 5 advance the count once every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 hold the count unchanged.
- R3: On each tick the count moves by exactly one. It rises from 0 to the ceiling, turns down at the ceiling and turns up again at 0, so one period lasts 2×ceiling ticks. A live ceiling of 0 holds the count at 0.
- R4: A write with `wr_addr` 0 (threshold A), 1 (threshold B) or 2 (dedicated ceiling) changes only a shadow register. The live copies take the shadow values on a tick that finds the count at 0, and at no other time.
- R5: With `top_sel` = 0 the ceiling is the live dedicated ceiling. With `top_sel` = 1 it is channel A's live threshold.
- R6: Mode 2 (non-inverted): the pin is high while count < threshold, and at count = threshold when the last step was downward. Otherwise it is low. This means the pin clears on an upward match and sets on a downward match, and it stays high for 2×threshold ticks per period.
- R7: Mode 3 (inverted) drives the exact complement of the mode 2 waveform.
- R8: A threshold of 0 holds a mode 2 pin low and a mode 3 pin high. A threshold at or above the ceiling holds a mode 2 pin high and a mode 3 pin low.
- R9: With `top_sel` = 1 and `mode_a` = 1, pin A starts at 0 and flips each time the count turns down at the ceiling, giving a 50% square wave with 2×ceiling ticks per level. With `top_sel` = 1 and `mode_a` = 2 or 3, pin A is 0.
- R10: Mode 0 forces the pin to 0. Mode 1 forces pin B to 0, and also forces pin A to 0 when `top_sel` = 0.
- R11: A pin whose output-enable is 0 is 0 after the next clock edge, whatever its waveform.
- R12: The count and both pins are registered and change on the same clock edge. Changes to mode, enable and `top_sel` reach the pins on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Prescaler code: 0 stop, 1 ÷1, 2 ÷8, 3 ÷64, 4 ÷256, 5 ÷1024, 6–7 stop |
| top_sel | input | 1 | 0: dedicated ceiling register, 1: channel A threshold is the ceiling |
| mode_a | input | 2 | Channel A mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| mode_b | input | 2 | Channel B mode: 0 off, 1 off, 2 non-inverted, 3 inverted |
| oe_a | input | 1 | Output enable for pin A |
| oe_b | input | 1 | Output enable for pin B |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 2 | Write target: 0 threshold A, 1 threshold B, 2 ceiling |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| pin_a | output | 1 | Channel A output pin |
| pin_b | output | 1 | Channel B output pin |

## Verification
The bench builds the block at its defaults: a 16-bit count and a 10-bit prescale divider. The divider's full depth keeps the ÷1024 step interval within reach. Ceilings of 2 to 7 keep every period to a few ticks, so turnarounds, bottom-of-count loads, threshold extremes and toggle edges recur many times in a short run. Each prescaler code, including the stopped ones, can also be swept within the cycle budget.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      CM_OFF    = 2'd0,
      CM_TOGGLE = 2'd1,
      CM_NONINV = 2'd2,
      CM_INV    = 2'd3
   } cmp_mode_e;

   typedef enum logic [1:0] {
      RA_CMP_A = 2'd0,
      RA_CMP_B = 2'd1,
      RA_TOP   = 2'd2
   } reg_addr_e;

   localparam int unsigned NUM_BUF      = 3;
   localparam int unsigned DIV_LOG2_MAX = 10;

   // log2 of the division ratio for each running prescaler code
   function automatic logic [3:0] presc_log2(input logic [2:0] sel);
      logic [3:0] r;
      unique case (sel)
         3'd2:    r = 4'd3;
         3'd3:    r = 4'd6;
         3'd4:    r = 4'd8;
         3'd5:    r = 4'd10;
         default: r = 4'd0;
      endcase
      return r;
   endfunction

   function automatic logic presc_runs(input logic [2:0] sel);
      return (sel != 3'd0) && (sel <= 3'd5);
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_pkg::*;
#(
   parameter int unsigned DIV_W = 10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [2:0] sel,
   output logic       tick
);

   if (DIV_W < DIV_LOG2_MAX) begin : g_bad_div
      $error("pwm_prescaler: DIV_W must cover the largest division ratio");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic             run;

   assign run  = presc_runs(sel);
   assign mask = (DIV_W'(1) << presc_log2(sel)) - DIV_W'(1);
   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/pwm_updown.sv
module pwm_updown
   import pwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             top_sel,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_n,
   output logic             up_n,
   output logic             peak,
   output logic [CNT_W-1:0] cmp_a_n,
   output logic [CNT_W-1:0] cmp_b_n,
   output logic [CNT_W-1:0] top_n,
   output logic [CNT_W-1:0] cmp_b_act
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pwm_updown: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] buf_q [NUM_BUF];
   logic [CNT_W-1:0] act_q [NUM_BUF];
   logic [CNT_W-1:0] act_n [NUM_BUF];
   logic             up_q;
   logic             at_bottom;
   logic             load;
   logic [CNT_W-1:0] top_q;

   assign at_bottom = (cnt_q == '0);
   assign load      = tick && at_bottom;

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
      always_ff @(posedge clk) begin
         if (rst) begin
            buf_q[g] <= '0;
         end else if (wr_en && (wr_addr == 2'(g))) begin
            buf_q[g] <= wr_data;
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            act_q[g] <= '0;
         end else if (load) begin
            act_q[g] <= buf_q[g];
         end
      end

      assign act_n[g] = load ? buf_q[g] : act_q[g];
   end

   assign top_q     = top_sel ? act_q[RA_CMP_A] : act_q[RA_TOP];
   assign top_n     = top_sel ? act_n[RA_CMP_A] : act_n[RA_TOP];
   assign cmp_a_n   = act_n[RA_CMP_A];
   assign cmp_b_n   = act_n[RA_CMP_B];
   assign cmp_b_act = act_q[RA_CMP_B];

   always_comb begin
      cnt_n = cnt_q;
      up_n  = up_q;
      peak  = 1'b0;
      if (tick) begin
         if (at_bottom) begin
            up_n  = 1'b1;
            cnt_n = (top_n != '0) ? CNT_W'(1) : '0;
         end else if (up_q) begin
            if (cnt_q >= top_q) begin
               cnt_n = cnt_q - CNT_W'(1);
               up_n  = 1'b0;
               peak  = 1'b1;
            end else begin
               cnt_n = cnt_q + CNT_W'(1);
            end
         end else begin
            cnt_n = cnt_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_n;
         up_q  <= up_n;
      end
   end

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
   import pwm_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter bit          HAS_TOGGLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_n,
   input  logic             up_n,
   input  logic [CNT_W-1:0] cmp_n,
   input  logic [CNT_W-1:0] top_n,
   input  logic [1:0]       mode,
   input  logic             oe,
   input  logic             tog_en,
   input  logic             peak,
   output logic             pin_q
);

   logic lvl;
   logic val;
   logic tog_val;
   logic is_top;

   always_comb begin
      if (cmp_n == '0) begin
         lvl = 1'b0;
      end else if (cmp_n >= top_n) begin
         lvl = 1'b1;
      end else begin
         lvl = (cnt_n < cmp_n) || ((cnt_n == cmp_n) && !up_n);
      end
   end

   if (HAS_TOGGLE) begin : g_tog
      logic tog_q;
      logic tog_n;
      assign tog_n   = tog_q ^ (peak && tog_en && (mode == CM_TOGGLE));
      assign tog_val = tog_en ? tog_n : 1'b0;
      assign is_top  = tog_en;
      always_ff @(posedge clk) begin
         if (rst) begin
            tog_q <= 1'b0;
         end else begin
            tog_q <= tog_n;
         end
      end
   end else begin : g_plain
      logic unused_tog;
      assign unused_tog = ^{tog_en, peak};
      assign tog_val    = 1'b0;
      assign is_top     = 1'b0;
   end

   always_comb begin
      unique case (cmp_mode_e'(mode))
         CM_NONINV: val = !is_top && lvl;
         CM_INV:    val = !is_top && !lvl;
         CM_TOGGLE: val = tog_val;
         default:   val = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pin_q <= 1'b0;
      end else begin
         pin_q <= oe && val;
      end
   end

endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm
   import pwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       presc_sel,
   input  logic             top_sel,
   input  logic [1:0]       mode_a,
   input  logic [1:0]       mode_b,
   input  logic             oe_a,
   input  logic             oe_b,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pin_a,
   output logic             pin_b
);

   localparam int unsigned NUM_CH = 2;

   logic             tick;
   logic [CNT_W-1:0] cnt_n;
   logic             up_n;
   logic             peak;
   logic [CNT_W-1:0] cmp_a_n;
   logic [CNT_W-1:0] cmp_b_n;
   logic [CNT_W-1:0] top_n;
   logic [CNT_W-1:0] cmp_b_act;

   logic [1:0]       mode_v [NUM_CH];
   logic             oe_v   [NUM_CH];
   logic [CNT_W-1:0] cmp_v  [NUM_CH];
   logic             pin_v  [NUM_CH];

   assign mode_v[0] = mode_a;
   assign mode_v[1] = mode_b;
   assign oe_v[0]   = oe_a;
   assign oe_v[1]   = oe_b;
   assign cmp_v[0]  = cmp_a_n;
   assign cmp_v[1]  = cmp_b_n;

   pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk  (clk),
      .rst  (rst),
      .sel  (presc_sel),
      .tick (tick)
   );

   pwm_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .top_sel   (top_sel),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cnt_q     (cnt_o),
      .cnt_n     (cnt_n),
      .up_n      (up_n),
      .peak      (peak),
      .cmp_a_n   (cmp_a_n),
      .cmp_b_n   (cmp_b_n),
      .top_n     (top_n),
      .cmp_b_act (cmp_b_act)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_wave #(.CNT_W(CNT_W), .HAS_TOGGLE(c == 0)) u_wave (
         .clk    (clk),
         .rst    (rst),
         .cnt_n  (cnt_n),
         .up_n   (up_n),
         .cmp_n  (cmp_v[c]),
         .top_n  (top_n),
         .mode   (mode_v[c]),
         .oe     (oe_v[c]),
         .tog_en (top_sel),
         .peak   (peak),
         .pin_q  (pin_v[c])
      );
   end

   assign pin_a = pin_v[0];
   assign pin_b = pin_v[1];

endmodule

// File: rtl/pwm_chk.sv
module pwm_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [2:0]       presc_sel,
   input logic             top_sel,
   input logic [1:0]       mode_a,
   input logic [1:0]       mode_b,
   input logic             oe_a,
   input logic             oe_b,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_b_act,
   input logic             pin_a,
   input logic             pin_b
);

   // R2
   stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (presc_sel == 3'd0 || presc_sel > 3'd5) |=> $stable(cnt));

   // R3
   unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(cnt) |-> (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
                         ({1'b0, cnt} + 1'b1 == {1'b0, $past(cnt)})));

   // R4
   bottom_load_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(cmp_b_act) |-> ($past(cnt) == '0));

   // R9
   a_is_top_chk: assert property (@(posedge clk) disable iff (rst)
      (top_sel && mode_a[1]) |=> !pin_a);

   // R10
   b_off_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_b == 2'd0 || mode_b == 2'd1) |=> !pin_b);

   // R11
   oe_a_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !oe_a |=> !pin_a);

   // R11
   oe_b_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !oe_b |=> !pin_b);

endmodule

bind dual_slope_pwm pwm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .presc_sel (presc_sel),
   .top_sel   (top_sel),
   .mode_a    (mode_a),
   .mode_b    (mode_b),
   .oe_a      (oe_a),
   .oe_b      (oe_b),
   .cnt       (cnt_o),
   .cmp_b_act (cmp_b_act),
   .pin_a     (pin_a),
   .pin_b     (pin_b)
);

// File: tb/tb_dual_slope_pwm.sv
module tb_dual_slope_pwm;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  presc_sel = 3'd0;
   logic        top_sel = 1'b0;
   logic [1:0]  mode_a = 2'd0;
   logic [1:0]  mode_b = 2'd0;
   logic        oe_a = 1'b0;
   logic        oe_b = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] cnt_o;
   logic        pin_a;
   logic        pin_b;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 1'b0;
   string tag      = "R1";

   always #5 clk = ~clk;

   dual_slope_pwm dut (
      .clk(clk), .rst(rst), .presc_sel(presc_sel), .top_sel(top_sel),
      .mode_a(mode_a), .mode_b(mode_b), .oe_a(oe_a), .oe_b(oe_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_o(cnt_o), .pin_a(pin_a), .pin_b(pin_b)
   );

   typedef struct {
      logic [15:0] cnt;
      logic        pa;
      logic        pb;
      string       req;
   } exp_t;

   exp_t sb_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- reference model (driver side of the scoreboard) ----
   logic [15:0] m_cnt;
   bit          m_up;
   int          m_div;
   logic [15:0] m_buf [3];
   logic [15:0] m_act [3];
   bit          m_tog;

   function automatic bit wave_lvl(input logic [15:0] c, input bit up,
                                   input logic [15:0] thr, input logic [15:0] ceil);
      if (thr == 0) return 1'b0;             // R8 low end
      if (thr >= ceil) return 1'b1;          // R8 high end
      if (c < thr) return 1'b1;              // R6 below threshold
      if (c == thr && !up) return 1'b1;      // R6 set on downward match
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      exp_t        e;
      int          sh;
      bit          run, tick, load, peak;
      logic [15:0] ceil_q, ceil_n;
      if (rst) begin
         m_cnt = 0; m_up = 1; m_div = 0; m_tog = 0;
         for (int i = 0; i < 3; i++) begin m_buf[i] = 0; m_act[i] = 0; end
         e.cnt = 0; e.pa = 0; e.pb = 0;
      end else begin
         run = 1;
         case (presc_sel)
            3'd1: sh = 0;
            3'd2: sh = 3;
            3'd3: sh = 6;
            3'd4: sh = 8;
            3'd5: sh = 10;
            default: begin sh = 0; run = 0; end
         endcase
         tick  = run && ((m_div % (1 << sh)) == (1 << sh) - 1);
         m_div = run ? (m_div + 1) % 1024 : 0;
         ceil_q = top_sel ? m_act[0] : m_act[2];
         load = tick && (m_cnt == 0);
         peak = 0;
         if (load) for (int i = 0; i < 3; i++) m_act[i] = m_buf[i];
         if (wr_en && wr_addr < 3) m_buf[wr_addr] = wr_data;
         ceil_n = top_sel ? m_act[0] : m_act[2];
         if (tick) begin
            if (m_cnt == 0) begin
               m_up = 1;
               m_cnt = (ceil_n != 0) ? 16'd1 : 16'd0;
            end else if (m_up && m_cnt >= ceil_q) begin
               m_up = 0; m_cnt = m_cnt - 1; peak = 1;
            end else if (m_up) begin
               m_cnt = m_cnt + 1;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
         if (peak && top_sel && mode_a == 2'd1) m_tog = !m_tog;
         e.cnt = m_cnt;
         case (mode_a)
            2'd2: e.pa = !top_sel && wave_lvl(m_cnt, m_up, m_act[0], ceil_n);
            2'd3: e.pa = !top_sel && !wave_lvl(m_cnt, m_up, m_act[0], ceil_n);
            2'd1: e.pa = top_sel && m_tog;
            default: e.pa = 0;
         endcase
         case (mode_b)
            2'd2: e.pb = wave_lvl(m_cnt, m_up, m_act[1], ceil_n);
            2'd3: e.pb = !wave_lvl(m_cnt, m_up, m_act[1], ceil_n);
            default: e.pb = 0;
         endcase
         e.pa = e.pa && oe_a;
         e.pb = e.pb && oe_b;
      end
      e.req = tag;
      sb_q.push_back(e);
   end

   // ---------------- monitor -------------------------------------------
   always @(negedge clk) begin
      exp_t e;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         chk(cnt_o == e.cnt, e.req, "count", int'(cnt_o), int'(e.cnt));
         chk(pin_a == e.pa, e.req, "pin_a", int'(pin_a), int'(e.pa));
         chk(pin_b == e.pb, e.req, "pin_b", int'(pin_b), int'(e.pb));
      end
   end

   // ---------------- stimulus helpers -----------------------------------
   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_change();
      logic [15:0] p;
      p = cnt_o;
      do @(negedge clk); while (cnt_o == p);
   endtask

   task automatic step_interval(input logic [2:0] sel, input int exp_n);
      int c;
      logic [15:0] p;
      @(negedge clk);
      presc_sel = sel;
      wait_change();
      p = cnt_o; c = 0;
      do begin @(negedge clk); c++; end while (cnt_o == p);
      // R2 step interval
      chk(c == exp_n, "R2", "step interval", c, exp_n);
   endtask

   task automatic high_run(input bit use_a, input bit level, input int exp_n,
                           input string req);
      int c;
      do @(negedge clk); while ((use_a ? pin_a : pin_b) == level);
      do @(negedge clk); while ((use_a ? pin_a : pin_b) != level);
      c = 0;
      do begin @(negedge clk); c++; end while ((use_a ? pin_a : pin_b) == level);
      chk(c == exp_n, req, "level run length", c, exp_n);
   endtask

   // ---------------- scenario ------------------------------------------
   initial begin
      int mx;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(cnt_o == 0, "R1", "count after reset", int'(cnt_o), 0);
      chk(pin_a == 0 && pin_b == 0, "R1", "pins after reset", int'({pin_a, pin_b}), 0);
      idle(10);

      // R3 counting 0..5..0 with dedicated ceiling
      tag = "R3";
      wr(2'd2, 16'd5);
      wr(2'd1, 16'd2);
      mode_b = 2'd2; oe_b = 1'b1;
      presc_sel = 3'd1;
      mx = 0;
      repeat (30) begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end
      chk(mx == 5, "R3", "peak count", mx, 5);

      // R6 non-inverted: high for 2*threshold, low for 2*(ceiling-threshold)
      tag = "R6";
      high_run(1'b0, 1'b1, 4, "R6");
      high_run(1'b0, 1'b0, 6, "R6");

      // R7 inverted
      tag = "R7";
      @(negedge clk); mode_b = 2'd3;
      high_run(1'b0, 1'b0, 4, "R7");
      high_run(1'b0, 1'b1, 6, "R7");

      // R4 shadow writes mid-period take effect at bottom only
      tag = "R4";
      mode_b = 2'd2;
      wr(2'd1, 16'd4);
      wr(2'd2, 16'd7);
      idle(40);
      high_run(1'b0, 1'b1, 8, "R4");

      // R8 extremes
      tag = "R8";
      wr(2'd1, 16'd0);
      idle(30);
      chk(pin_b == 0, "R8", "threshold 0 non-inverted", int'(pin_b), 0);
      mode_b = 2'd3; idle(20);
      chk(pin_b == 1, "R8", "threshold 0 inverted", int'(pin_b), 1);
      wr(2'd1, 16'd7); idle(30);
      chk(pin_b == 0, "R8", "threshold=ceiling inverted", int'(pin_b), 0);
      mode_b = 2'd2; wr(2'd1, 16'd9); idle(30);
      chk(pin_b == 1, "R8", "threshold above ceiling", int'(pin_b), 1);

      // R5 ceiling from channel A, R9 toggle output
      tag = "R5";
      wr(2'd0, 16'd3);
      idle(20);
      @(negedge clk); top_sel = 1'b1;
      idle(20);
      mx = 0;
      repeat (20) begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end
      chk(mx == 3, "R5", "peak with A as ceiling", mx, 3);
      tag = "R9";
      mode_a = 2'd1; oe_a = 1'b1;
      high_run(1'b1, 1'b1, 6, "R9");
      high_run(1'b1, 1'b0, 6, "R9");
      mode_a = 2'd2; idle(15);
      chk(pin_a == 0, "R9", "A as ceiling in PWM mode", int'(pin_a), 0);

      // R10 disconnected modes
      tag = "R10";
      @(negedge clk); top_sel = 1'b0; mode_a = 2'd1; mode_b = 2'd1;
      idle(25);
      chk(pin_a == 0, "R10", "A toggle mode without ceiling role", int'(pin_a), 0);
      mode_b = 2'd0; mode_a = 2'd0; idle(20);

      // R11 output enable gating
      tag = "R11";
      mode_a = 2'd3; mode_b = 2'd2; wr(2'd1, 16'd2); idle(20);
      oe_a = 1'b0; oe_b = 1'b0; idle(25);
      chk(pin_a == 0 && pin_b == 0, "R11", "pins gated", int'({pin_a, pin_b}), 0);
      oe_a = 1'b1; oe_b = 1'b1;

      // R12 pins and count stay lock-step under the registered timing
      tag = "R12";
      wr(2'd2, 16'd2);
      idle(30);

      // R2 prescaler codes
      tag = "R2";
      step_interval(3'd2, 8);
      step_interval(3'd3, 64);
      step_interval(3'd4, 256);
      step_interval(3'd5, 1024);
      step_interval(3'd1, 1);
      @(negedge clk); presc_sel = 3'd6;
      mx = int'(cnt_o); idle(40);
      chk(int'(cnt_o) == mx, "R2", "code 6 holds", int'(cnt_o), mx);
      presc_sel = 3'd7; idle(40);
      chk(int'(cnt_o) == mx, "R2", "code 7 holds", int'(cnt_o), mx);
      presc_sel = 3'd0; idle(40);
      chk(int'(cnt_o) == mx, "R2", "code 0 holds", int'(cnt_o), mx);

      // R3 ceiling of 0 parks the counter at 0
      tag = "R3";
      presc_sel = 3'd1;
      wr(2'd2, 16'd0);
      idle(30);
      chk(cnt_o == 0, "R3", "ceiling 0 parks", int'(cnt_o), 0);

      idle(2);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule